// File: doc/BRIEF.md
# Codec Status Frame Generator

This block is the codec side of a serial audio link, in the direction from codec to controller. Each frame is built from a 16-bit tag field and twelve 20-bit slots, and it is shifted out one bit per bit clock with the most significant bit first. The controller raises `syncIn` to start a frame. On the rising edge of the bit clock where the block first sees sync high, it loads a complete frame and drives that frame's first bit.

A register read request arrives on `reqValid`/`reqIndex`. The block answers it in the frame after the frame in which the request arrived. The answer puts the index into slot 1 and the register contents into slot 2. The block fetches the contents from an external register file through `rdIndex`/`regData`. Index 0 is the reset register, and the block answers it with a fixed identification word. A write to index 0 produces a one-cycle `regsReset` strobe for the register file.

Slot 1 also carries the two sample request flags, which are active low. Slots 3 and 4 carry the left and right record samples. Every other field is zero.

Top module: `codec_status_framer`

## Requirements
- R1: After reset `sdataOut` is 0. On the first bit clock edge where `syncIn` is sampled high after being sampled low (the load edge), `sdataOut` takes frame bit 255 (the tag MSB). It then shifts out one frame bit per edge, MSB first, for 256 bits in total. After the last bit `sdataOut` stays 0 until the next load edge.
- R2: The tag field is frame bits 255:240. Bit 255 is `codecReady`, and bits 254 and 253 are 1 exactly when the frame carries a read response. Bit 252 is `leftValid` and bit 251 is `rightValid`. Bits 250:240 are 0. All of these inputs are sampled at the load edge.
- R3: A request sampled on any edge after a load edge, up to and including the edge before the next load edge, is answered in the next frame. Slot 1 (frame bits 239:220) carries the 7-bit index in its bits 18:12. Slot 2 (frame bits 219:200) carries the 16-bit data in its bits 19:4. A frame without a response has zeros in both of these fields.
- R4: If several requests arrive before a response is sent, only the last one is answered. `rdIndex` shows the index of the most recent request one edge after that request.
- R5: The response data for index 0 is 0x0D50, regardless of `regData`. For any other index it is `regData`, sampled at the load edge while `rdIndex` holds that index.
- R6: Slot 1 bit 11 is the inverse of `needLeft` and bit 10 is the inverse of `needRight` (0 means send a sample). Slot 1 bits 19 and 9:0 are 0, and slot 2 bits 3:0 are 0.
- R7: Slot 3 (frame bits 199:180) carries the 18-bit left sample in its bits 19:2, followed by two zero bits. Slot 4 (frame bits 179:160) carries the right sample in the same layout. A slot whose valid input is low is all zeros. Samples are captured at the load edge, so later changes to the inputs do not reach the frame being sent.
- R8: Slots 5 to 12 (frame bits 159:0) are all zeros.
- R9: When `wrValid` is sampled high with `wrIndex` equal to 0, `regsReset` is 1 for exactly the following cycle. A write to any other index leaves it 0.
- R10: Holding `syncIn` high causes no further load. A new rising edge of `syncIn` in the middle of a frame abandons that frame and starts a new frame at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bitClk | input | 1 | Bit clock; all state changes on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| syncIn | input | 1 | Frame sync from the controller; a rising edge starts a frame |
| codecReady | input | 1 | Ready flag placed in tag bit 15 |
| reqValid | input | 1 | Register read request strobe |
| reqIndex | input | 7 | Register index of the read request |
| rdIndex | output | 7 | Index of the pending read, sent to the register file |
| regData | input | 16 | Register file contents at `rdIndex` |
| wrValid | input | 1 | Register write strobe |
| wrIndex | input | 7 | Register index of the write |
| regsReset | output | 1 | One-cycle strobe that resets the register file |
| needLeft | input | 1 | High when the codec wants a left sample in the next frame |
| needRight | input | 1 | High when the codec wants a right sample in the next frame |
| leftValid | input | 1 | Left record sample is valid |
| rightValid | input | 1 | Right record sample is valid |
| leftSample | input | 18 | Left record sample |
| rightSample | input | 18 | Right record sample |
| sdataOut | output | 1 | Serial frame data |

## Verification
The hardest case to produce is a read whose response frame is not the frame right after the request. This happens when a frame is cut short by a new sync rising edge, or when a second request replaces the first before any response goes out. To reach it, the stimulus truncates a frame after a request, issues two requests inside one frame, and places requests late in a frame. A reference model of the pending request is kept across frames. The load-edge capture is tested by changing the samples and the flags a few bits into each frame.

// File: rtl/stat_frame_pkg.sv
package stat_frame_pkg;
  // Strobes passed from control to datapath
  typedef struct packed {
    logic load;       // load a fresh frame on this edge
    logic carryResp;  // the frame being loaded carries a read response
  } frameStrobes_t;
endpackage

// File: rtl/stat_frame_ctrl.sv
module stat_frame_ctrl
  import stat_frame_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             syncIn,
  input  logic             reqValid,
  input  logic [IDX_W-1:0] reqIndex,
  input  logic             wrValid,
  input  logic [IDX_W-1:0] wrIndex,
  output frameStrobes_t    strobes,
  output logic [IDX_W-1:0] pendIdx,
  output logic             regsReset
);
  logic syncPrev;
  logic pendValid;

  // Tracks sync in every cycle, so a level held through reset is never seen as a rise
  always_ff @(posedge clk) syncPrev <= syncIn;

  always_comb begin
    strobes.load      = syncIn & ~syncPrev;
    strobes.carryResp = pendValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendIdx   <= '0;
      regsReset <= 1'b0;
    end else begin
      if (reqValid) begin
        pendValid <= 1'b1;
        pendIdx   <= reqIndex;
      end else if (strobes.load) begin
        pendValid <= 1'b0;
      end
      regsReset <= wrValid && (wrIndex == '0);
    end
  end
endmodule

// File: rtl/stat_frame_dp.sv
module stat_frame_dp
  import stat_frame_pkg::*;
#(
  parameter int TAG_W     = 16,
  parameter int SLOT_W    = 20,
  parameter int NUM_SLOTS = 12,
  parameter int SAMPLE_W  = 18,
  parameter int IDX_W     = 7,
  parameter int DATA_W    = 16,
  parameter logic [DATA_W-1:0] RESET_ID = 16'h0D50
) (
  input  logic                clk,
  input  logic                rstN,
  input  frameStrobes_t       strobes,
  input  logic [IDX_W-1:0]    respIdx,
  input  logic [DATA_W-1:0]   regData,
  input  logic                codecReady,
  input  logic                leftValid,
  input  logic                rightValid,
  input  logic                needLeft,
  input  logic                needRight,
  input  logic [SAMPLE_W-1:0] leftSample,
  input  logic [SAMPLE_W-1:0] rightSample,
  output logic                sdataOut
);
  localparam int FRAME_W = TAG_W + SLOT_W * NUM_SLOTS;
  localparam int TAG_LO  = FRAME_W - TAG_W;

  function automatic int slotBit(input int slot, input int b);
    return FRAME_W - TAG_W - slot * SLOT_W + b;
  endfunction

  logic [FRAME_W-1:0] frameBits;
  logic [FRAME_W-1:0] shiftQ;
  logic [DATA_W-1:0]  respData;

  assign respData = (respIdx == '0) ? RESET_ID : regData;

  always_comb begin
    frameBits = '0;
    // tag field
    frameBits[TAG_LO + 15] = codecReady;
    frameBits[TAG_LO + 14] = strobes.carryResp;
    frameBits[TAG_LO + 13] = strobes.carryResp;
    frameBits[TAG_LO + 12] = leftValid;
    frameBits[TAG_LO + 11] = rightValid;
    // slot 1: echoed index and active-low sample requests
    if (strobes.carryResp) begin
      frameBits[slotBit(1, SLOT_W - 2) -: IDX_W] = respIdx;
      frameBits[slotBit(2, SLOT_W - 1) -: DATA_W] = respData;
    end
    frameBits[slotBit(1, 11)] = ~needLeft;
    frameBits[slotBit(1, 10)] = ~needRight;
    // slots 3 and 4: samples, MSB aligned, low bits stay zero
    if (leftValid)  frameBits[slotBit(3, SLOT_W - 1) -: SAMPLE_W] = leftSample;
    if (rightValid) frameBits[slotBit(4, SLOT_W - 1) -: SAMPLE_W] = rightSample;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftQ   <= '0;
      sdataOut <= 1'b0;
    end else if (strobes.load) begin
      sdataOut <= frameBits[FRAME_W-1];
      shiftQ   <= {frameBits[FRAME_W-2:0], 1'b0};
    end else begin
      sdataOut <= shiftQ[FRAME_W-1];
      shiftQ   <= {shiftQ[FRAME_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/codec_status_framer.sv
module codec_status_framer
  import stat_frame_pkg::*;
#(
  parameter int TAG_W     = 16,
  parameter int SLOT_W    = 20,
  parameter int NUM_SLOTS = 12,
  parameter int SAMPLE_W  = 18,
  parameter int IDX_W     = 7,
  parameter int DATA_W    = 16
) (
  input  logic                bitClk,
  input  logic                rstN,
  input  logic                syncIn,
  input  logic                codecReady,
  input  logic                reqValid,
  input  logic [IDX_W-1:0]    reqIndex,
  output logic [IDX_W-1:0]    rdIndex,
  input  logic [DATA_W-1:0]   regData,
  input  logic                wrValid,
  input  logic [IDX_W-1:0]    wrIndex,
  output logic                regsReset,
  input  logic                needLeft,
  input  logic                needRight,
  input  logic                leftValid,
  input  logic                rightValid,
  input  logic [SAMPLE_W-1:0] leftSample,
  input  logic [SAMPLE_W-1:0] rightSample,
  output logic                sdataOut
);
  frameStrobes_t strobes;

  stat_frame_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk(bitClk), .rstN(rstN), .syncIn(syncIn),
    .reqValid(reqValid), .reqIndex(reqIndex),
    .wrValid(wrValid), .wrIndex(wrIndex),
    .strobes(strobes), .pendIdx(rdIndex), .regsReset(regsReset)
  );

  stat_frame_dp #(
    .TAG_W(TAG_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS),
    .SAMPLE_W(SAMPLE_W), .IDX_W(IDX_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk(bitClk), .rstN(rstN), .strobes(strobes),
    .respIdx(rdIndex), .regData(regData), .codecReady(codecReady),
    .leftValid(leftValid), .rightValid(rightValid),
    .needLeft(needLeft), .needRight(needRight),
    .leftSample(leftSample), .rightSample(rightSample),
    .sdataOut(sdataOut)
  );
endmodule

// File: rtl/stat_frame_checker.sv
module stat_frame_checker #(
  parameter int IDX_W = 7
) (
  input logic             clk,
  input logic             rstN,
  input logic             syncIn,
  input logic             codecReady,
  input logic             reqValid,
  input logic [IDX_W-1:0] reqIndex,
  input logic [IDX_W-1:0] rdIndex,
  input logic             wrValid,
  input logic [IDX_W-1:0] wrIndex,
  input logic             regsReset,
  input logic             sdataOut
);
  // R1, R2: the first bit after a sync rise is the ready flag
  a_r1_tag_first: assert property (@(posedge clk) disable iff (!rstN)
    (syncIn && !$past(syncIn)) |=> (sdataOut == $past(codecReady)));

  // R4: rdIndex follows the latest request
  a_r4_latest_index: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (rdIndex == $past(reqIndex)));

  // R4: without a request the pending index is kept
  a_r4_index_hold: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> $stable(rdIndex));

  // R9: a write to index 0 yields the reset strobe
  a_r9_reset_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrIndex == '0) |=> regsReset);

  // R9: no strobe without a write to index 0
  a_r9_reset_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !(wrValid && wrIndex == '0) |=> !regsReset);
endmodule

bind codec_status_framer stat_frame_checker #(.IDX_W(IDX_W)) u_checker (
  .clk(bitClk), .rstN(rstN), .syncIn(syncIn), .codecReady(codecReady),
  .reqValid(reqValid), .reqIndex(reqIndex), .rdIndex(rdIndex),
  .wrValid(wrValid), .wrIndex(wrIndex), .regsReset(regsReset),
  .sdataOut(sdataOut)
);

// File: tb/test_codec_status_framer.sv
module test_codec_status_framer;
  logic        bitClk = 1'b0;
  logic        rstN = 1'b0;
  logic        syncIn = 1'b0;
  logic        codecReady = 1'b0;
  logic        reqValid = 1'b0;
  logic [6:0]  reqIndex = '0;
  logic [6:0]  rdIndex;
  logic [15:0] regData;
  logic        wrValid = 1'b0;
  logic [6:0]  wrIndex = '0;
  logic        regsReset;
  logic        needLeft = 1'b0, needRight = 1'b0;
  logic        leftValid = 1'b0, rightValid = 1'b0;
  logic [17:0] leftSample = '0, rightSample = '0;
  logic        sdataOut;

  int nChecks = 0;
  int nFails  = 0;
  bit pV = 1'b0;
  logic [6:0] pI = '0;

  always #10 bitClk = ~bitClk;   // 50 MHz

  // Bench register file model
  function automatic logic [15:0] regModel(input logic [6:0] idx);
    return {idx ^ 7'h2A, idx[3:0], 5'h13};
  endfunction
  assign regData = regModel(rdIndex);

  codec_status_framer i_codec_status_framer (
    .bitClk(bitClk), .rstN(rstN), .syncIn(syncIn), .codecReady(codecReady),
    .reqValid(reqValid), .reqIndex(reqIndex), .rdIndex(rdIndex),
    .regData(regData), .wrValid(wrValid), .wrIndex(wrIndex),
    .regsReset(regsReset), .needLeft(needLeft), .needRight(needRight),
    .leftValid(leftValid), .rightValid(rightValid),
    .leftSample(leftSample), .rightSample(rightSample), .sdataOut(sdataOut)
  );

  task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] buildFrame(
      input bit rdy, input bit resp, input logic [6:0] idx, input logic [15:0] data,
      input bit nl, input bit nr, input bit lv, input bit rv,
      input logic [17:0] l, input logic [17:0] r);
    logic [255:0] f = '0;
    f[255] = rdy; f[254] = resp; f[253] = resp; f[252] = lv; f[251] = rv;
    if (resp) begin
      f[238:232] = idx;      // slot 1 bits 18:12
      f[219:204] = data;     // slot 2 bits 19:4
    end
    f[231] = ~nl;            // slot 1 bit 11
    f[230] = ~nr;            // slot 1 bit 10
    if (lv) f[199:182] = l;
    if (rv) f[179:162] = r;
    return f;
  endfunction

  task automatic randInputs();
    codecReady  = ($urandom % 4) != 0;
    needLeft    = $urandom % 2;
    needRight   = $urandom % 2;
    leftValid   = ($urandom % 3) != 0;
    rightValid  = ($urandom % 3) != 0;
    leftSample  = 18'($urandom);
    rightSample = 18'($urandom);
  endtask

  // Called at a negedge with syncIn low; runs len bits of one frame
  task automatic doFrame(input bit wantA, input logic [6:0] idxA, input int atA,
                         input bit wantB, input logic [6:0] idxB, input int atB,
                         input int len, input string why);
    logic [255:0] exp, cap;
    bit respV;
    logic [15:0] dat;
    randInputs();
    respV = pV;
    dat = (pI == 7'd0) ? 16'h0D50 : regModel(pI);
    exp = buildFrame(codecReady, respV, pI, dat, needLeft, needRight,
                     leftValid, rightValid, leftSample, rightSample);
    pV = 1'b0;
    cap = '0;
    syncIn = 1'b1;
    for (int k = 0; k < len; k++) begin
      @(posedge bitClk); @(negedge bitClk);
      cap[255-k] = sdataOut;
      reqValid = 1'b0;
      if (k == 16) syncIn = 1'b0;
      if (k == 5) randInputs();   // R7: capture at load edge only
      if (wantA && k == atA) begin reqValid = 1'b1; reqIndex = idxA; pV = 1'b1; pI = idxA; end
      if (wantB && k == atB) begin reqValid = 1'b1; reqIndex = idxB; pV = 1'b1; pI = idxB; end
    end
    reqValid = 1'b0;
    if (len == 256) begin
      check(cap[255:240] == exp[255:240], {why, " R2 tag"}, 256'(cap[255:240]), 256'(exp[255:240]));
      check(cap[239:220] == exp[239:220], {why, " R3 R4 R6 slot1"}, 256'(cap[239:220]), 256'(exp[239:220]));
      check(cap[219:200] == exp[219:200], {why, " R3 R5 R6 slot2"}, 256'(cap[219:200]), 256'(exp[219:200]));
      check(cap[199:160] == exp[199:160], {why, " R7 samples"}, 256'(cap[199:160]), 256'(exp[199:160]));
      check(cap[159:0] == exp[159:0], {why, " R8 reserved"}, 256'(cap[159:0]), 256'(exp[159:0]));
      for (int j = 0; j < 2; j++) begin
        @(posedge bitClk); @(negedge bitClk);
        check(sdataOut == 1'b0, {why, " R1 idle after frame"}, 256'(sdataOut), 256'(0));
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge bitClk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge bitClk);
    rstN = 1'b1;
    @(negedge bitClk);
    check(sdataOut == 1'b0, "R1 reset sdataOut", 256'(sdataOut), 256'(0));
    check(regsReset == 1'b0, "R9 reset regsReset", 256'(regsReset), 256'(0));

    // R9: write decode
    wrValid = 1'b1; wrIndex = 7'd0;
    @(posedge bitClk); @(negedge bitClk);
    wrValid = 1'b0;
    check(regsReset == 1'b1, "R9 write idx0 strobe", 256'(regsReset), 256'(1));
    @(posedge bitClk); @(negedge bitClk);
    check(regsReset == 1'b0, "R9 strobe one cycle", 256'(regsReset), 256'(0));
    wrValid = 1'b1; wrIndex = 7'd5;
    @(posedge bitClk); @(negedge bitClk);
    wrValid = 1'b0;
    check(regsReset == 1'b0, "R9 write other idx", 256'(regsReset), 256'(0));

    // Directed frames
    doFrame(1, 7'h26, 40, 0, 0, 0, 256, "no-resp R10 sync-held");
    doFrame(1, 7'h00, 10, 1, 7'h13, 200, 256, "resp");
    doFrame(1, 7'h00, 254, 0, 0, 0, 256, "R4 two-req");
    doFrame(0, 0, 0, 0, 0, 0, 256, "R5 idx0");
    // R10: frame cut short by a new sync edge, with a request inside it
    doFrame(1, 7'h7F, 30, 0, 0, 0, 60, "cut");
    doFrame(0, 0, 0, 0, 0, 0, 256, "R10 restart");

    // Random frames
    for (int n = 0; n < 12; n++) begin
      bit a = $urandom % 2;
      bit b = $urandom % 3 == 0;
      int atA = $urandom % 200;
      doFrame(a, 7'($urandom), atA, b, 7'($urandom), atA + 1 + ($urandom % 50), 256, "rand");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule